// File: doc/BRIEF.md
# Pattern ROM Chip-Select Gate

This block decodes the CPU side of a small cartridge and gates its pattern memory. A CPU write anywhere in the upper half of the 64 KB address space is captured whole in an 8-bit control register. The low two bits of that byte act as a key. When they equal a static key configuration input, the single 8 KB pattern ROM is enabled. Any other write disables it. While the ROM is disabled, every pattern read returns zero.

The program ROM is unbanked. Its address is the CPU address taken linearly, and a 16 KB image repeats across both halves of the upper window. An optional work-RAM window sits at 0x6000–0x7FFF. CPU reads that hit neither memory return an open-bus byte supplied from outside. The register and the enable flag are brought out as read-only debug outputs.

Top module: `pattern_cs_gate`

## Requirements
- R1: A write strobe with cpu_addr in 0x8000–0xFFFF loads the full cpu_wdata byte into the control register (dbg_ctrl) at that clock edge.
- R2: On such a write, with key configuration cfg_key nonzero, dbg_en becomes 1 if cpu_wdata[1:0] equals cfg_key, and 0 otherwise.
- R3: With cfg_key equal to 0, no write ever sets dbg_en, so pattern reads stay at 0x00.
- R4: After reset, dbg_ctrl is 0x00 and dbg_en is 0, so pat_rdata is 0x00 until an enabling write.
- R5: pat_rom_addr follows pat_addr combinationally. pat_rdata equals pat_rom_data while dbg_en is 1, and 0x00 for every pat_addr while dbg_en is 0.
- R6: With a 32 KB program image, prg_addr equals cpu_addr[14:0], and a CPU read in 0x8000–0xFFFF returns prg_data on cpu_rdata (so 0xC000 reaches offset 0x4000).
- R7: With a 16 KB program image, prg_addr equals cpu_addr[13:0], so cpu_addr bit 14 has no effect and 0xC000 reaches offset 0x0000.
- R8: With work RAM present, addresses 0x6000–0x7FFF form the work-RAM window. A write there pulses wram_we with wram_addr = cpu_addr[12:0] and leaves the control register unchanged. A read there returns wram_rdata.
- R9: Without work RAM, wram_we never asserts, and reads in 0x6000–0x7FFF (and anything below 0x8000) return open_bus.
- R10: Writes below 0x8000, and cycles without a write strobe, leave dbg_ctrl and dbg_en unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_key | input | 2 | Static enable key; 0 means never enable |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| open_bus | input | 8 | Value returned for unmapped reads |
| cpu_rdata | output | 8 | CPU read data |
| prg_addr | output | 15 | Program ROM address (width from image size) |
| prg_data | input | 8 | Program ROM data |
| wram_addr | output | 13 | Work-RAM address |
| wram_wdata | output | 8 | Work-RAM write data |
| wram_we | output | 1 | Work-RAM write enable |
| wram_rdata | input | 8 | Work-RAM read data |
| pat_addr | input | 13 | Pattern bus address |
| pat_rom_addr | output | 13 | Pattern ROM address |
| pat_rom_data | input | 8 | Pattern ROM data |
| pat_rdata | output | 8 | Gated pattern read data |
| dbg_ctrl | output | 8 | Control register value |
| dbg_en | output | 1 | Pattern ROM enable flag |

## Verification
The control register and the enable flag change one clock edge after a write strobe. The bench drives each write at a falling edge and reads them back at the next falling edge. All read paths (CPU read data, ROM addresses, gated pattern data, work-RAM strobes) are combinational, so they are sampled 1 ns after the inputs change in the same half cycle. After reset is released, the bench waits for the two-stage reset release before its first access.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PAT_AW  = 13;
  localparam int unsigned WRAM_AW = 13;

  typedef enum logic [1:0] {
    RSRC_OPEN = 2'd0,
    RSRC_PRG  = 2'd1,
    RSRC_WRAM = 2'd2
  } rsrc_e;

  typedef struct packed {
    logic ctrl_load;
    logic wram_hit;
    logic prg_hit;
  } dec_t;
endpackage

// File: rtl/pcg_reset_sync.sv
module pcg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcg_cpu_decode.sv
module pcg_cpu_decode
  import pcg_pkg::*;
#(
  parameter int unsigned PRG_KB   = 32,
  parameter bit          HAS_WRAM = 1'b1,
  localparam int unsigned PRG_AW  = $clog2(PRG_KB * 1024)
) (
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  open_bus,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [PRG_AW-1:0]  prg_addr,
  input  logic [DATA_W-1:0]  prg_data,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic [DATA_W-1:0]  wram_wdata,
  output logic               wram_we,
  input  logic [DATA_W-1:0]  wram_rdata,
  output dec_t               dec
);
  logic  prg_hit;
  logic  wram_hit;
  rsrc_e rsrc;

  assign prg_hit = cpu_addr[CPU_AW-1];

  generate
    if (HAS_WRAM) begin : g_wram
      assign wram_hit = (cpu_addr[CPU_AW-1:WRAM_AW] == 3'b011);
    end else begin : g_no_wram
      assign wram_hit = 1'b0;
    end
  endgenerate

  generate
    if (PRG_KB == 16) begin : g_prg16
      assign prg_addr = cpu_addr[13:0];
    end else begin : g_prg_lin
      assign prg_addr = cpu_addr[PRG_AW-1:0];
    end
  endgenerate

  assign wram_addr  = cpu_addr[WRAM_AW-1:0];
  assign wram_wdata = cpu_wdata;
  assign wram_we    = cpu_wr & wram_hit;

  always_comb begin
    if (prg_hit) begin
      rsrc = RSRC_PRG;
    end else if (wram_hit) begin
      rsrc = RSRC_WRAM;
    end else begin
      rsrc = RSRC_OPEN;
    end
  end

  always_comb begin
    unique case (rsrc)
      RSRC_PRG:  cpu_rdata = prg_data;
      RSRC_WRAM: cpu_rdata = wram_rdata;
      default:   cpu_rdata = open_bus;
    endcase
  end

  always_comb begin
    dec.prg_hit   = prg_hit;
    dec.wram_hit  = wram_hit;
    dec.ctrl_load = cpu_wr & prg_hit;
  end
endmodule

// File: rtl/pcg_key_reg.sv
module pcg_key_reg
  import pcg_pkg::*;
#(
  parameter int unsigned KEY_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [KEY_W-1:0]  cfg_key,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              en_q
);
  logic [DATA_W-1:0] ctrl_d;
  logic              en_d;
  logic              key_valid;
  logic              key_match;

  assign key_valid = (cfg_key != '0);
  assign key_match = key_valid && (wdata[KEY_W-1:0] == cfg_key);

  always_comb begin
    ctrl_d = ctrl_q;
    en_d   = en_q;
    if (load) begin
      ctrl_d = wdata;
      en_d   = key_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/pcg_pat_gate.sv
module pcg_pat_gate
  import pcg_pkg::*;
(
  input  logic              en,
  input  logic [PAT_AW-1:0] pat_addr,
  output logic [PAT_AW-1:0] pat_rom_addr,
  input  logic [DATA_W-1:0] pat_rom_data,
  output logic [DATA_W-1:0] pat_rdata
);
  assign pat_rom_addr = pat_addr;

  always_comb begin
    pat_rdata = '0;
    if (en) begin
      pat_rdata = pat_rom_data;
    end
  end
endmodule

// File: rtl/pattern_cs_gate.sv
module pattern_cs_gate
  import pcg_pkg::*;
#(
  parameter int unsigned PRG_KB      = 32,
  parameter bit          HAS_WRAM    = 1'b1,
  parameter int unsigned KEY_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [KEY_W-1:0]                  cfg_key,
  input  logic [CPU_AW-1:0]                 cpu_addr,
  input  logic [DATA_W-1:0]                 cpu_wdata,
  input  logic                              cpu_wr,
  input  logic [DATA_W-1:0]                 open_bus,
  output logic [DATA_W-1:0]                 cpu_rdata,
  output logic [$clog2(PRG_KB*1024)-1:0]    prg_addr,
  input  logic [DATA_W-1:0]                 prg_data,
  output logic [WRAM_AW-1:0]                wram_addr,
  output logic [DATA_W-1:0]                 wram_wdata,
  output logic                              wram_we,
  input  logic [DATA_W-1:0]                 wram_rdata,
  input  logic [PAT_AW-1:0]                 pat_addr,
  output logic [PAT_AW-1:0]                 pat_rom_addr,
  input  logic [DATA_W-1:0]                 pat_rom_data,
  output logic [DATA_W-1:0]                 pat_rdata,
  output logic [DATA_W-1:0]                 dbg_ctrl,
  output logic                              dbg_en
);
  logic rst_sync_n;
  dec_t dec;

  pcg_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcg_cpu_decode #(.PRG_KB(PRG_KB), .HAS_WRAM(HAS_WRAM)) u_dec (
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_wr     (cpu_wr),
    .open_bus   (open_bus),
    .cpu_rdata  (cpu_rdata),
    .prg_addr   (prg_addr),
    .prg_data   (prg_data),
    .wram_addr  (wram_addr),
    .wram_wdata (wram_wdata),
    .wram_we    (wram_we),
    .wram_rdata (wram_rdata),
    .dec        (dec)
  );

  pcg_key_reg #(.KEY_W(KEY_W)) u_key (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (dec.ctrl_load),
    .wdata   (cpu_wdata),
    .cfg_key (cfg_key),
    .ctrl_q  (dbg_ctrl),
    .en_q    (dbg_en)
  );

  pcg_pat_gate u_pat (
    .en           (dbg_en),
    .pat_addr     (pat_addr),
    .pat_rom_addr (pat_rom_addr),
    .pat_rom_data (pat_rom_data),
    .pat_rdata    (pat_rdata)
  );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import pcg_pkg::*;
#(
  parameter int unsigned KEY_W = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [KEY_W-1:0]  cfg_key,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_wr,
  input logic              wram_we,
  input logic [DATA_W-1:0] pat_rdata,
  input logic [DATA_W-1:0] dbg_ctrl,
  input logic              dbg_en
);
  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_wr && cpu_addr[15]) |=> (dbg_ctrl == $past(cpu_wdata)));

  p_key_match_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_wr && cpu_addr[15] && cfg_key != '0) |=>
      (dbg_en == ($past(cpu_wdata[KEY_W-1:0]) == $past(cfg_key))));

  p_key_zero_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_key == '0 && $stable(cfg_key)) |-> !dbg_en);

  p_gate_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dbg_en |-> (pat_rdata == '0));

  p_wram_we_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b011));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cpu_wr && cpu_addr[15]) |=> ($stable(dbg_ctrl) && $stable(dbg_en)));
endmodule

bind pattern_cs_gate pcg_checker #(.KEY_W(KEY_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_key    (cfg_key),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_wr     (cpu_wr),
  .wram_we    (wram_we),
  .pat_rdata  (pat_rdata),
  .dbg_ctrl   (dbg_ctrl),
  .dbg_en     (dbg_en)
);

// File: tb/tb_pattern_cs_gate.sv
module tb_pattern_cs_gate;
  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_key;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic [7:0]  open_bus;
  logic [12:0] pat_addr;

  logic [7:0]  cpu_rdata, wram_wdata, wram_rdata, pat_rdata, dbg_ctrl, pat_rom_data, prg_data;
  logic [14:0] prg_addr;
  logic [12:0] wram_addr, pat_rom_addr;
  logic        wram_we, dbg_en;

  logic [7:0]  s_cpu_rdata, s_wram_wdata, s_wram_rdata, s_pat_rdata, s_dbg_ctrl, s_pat_rom_data, s_prg_data;
  logic [13:0] s_prg_addr;
  logic [12:0] s_wram_addr, s_pat_rom_addr;
  logic        s_wram_we, s_dbg_en;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] m_ctrl;
  logic       m_en;

  function automatic logic [7:0] prg_f(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] pat_f(input logic [12:0] a);
    return a[7:0] | 8'h80;
  endfunction
  function automatic logic [7:0] wram_f(input logic [12:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  assign prg_data       = prg_f(prg_addr);
  assign s_prg_data     = prg_f({1'b0, s_prg_addr});
  assign pat_rom_data   = pat_f(pat_rom_addr);
  assign s_pat_rom_data = pat_f(s_pat_rom_addr);
  assign wram_rdata     = wram_f(wram_addr);
  assign s_wram_rdata   = wram_f(s_wram_addr);

  pattern_cs_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_key(cfg_key), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .open_bus(open_bus),
    .cpu_rdata(cpu_rdata), .prg_addr(prg_addr), .prg_data(prg_data),
    .wram_addr(wram_addr), .wram_wdata(wram_wdata), .wram_we(wram_we),
    .wram_rdata(wram_rdata), .pat_addr(pat_addr), .pat_rom_addr(pat_rom_addr),
    .pat_rom_data(pat_rom_data), .pat_rdata(pat_rdata), .dbg_ctrl(dbg_ctrl),
    .dbg_en(dbg_en)
  );

  pattern_cs_gate #(.PRG_KB(16), .HAS_WRAM(1'b0)) dut_small (
    .clk(clk), .rst_n(rst_n), .cfg_key(cfg_key), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .open_bus(open_bus),
    .cpu_rdata(s_cpu_rdata), .prg_addr(s_prg_addr), .prg_data(s_prg_data),
    .wram_addr(s_wram_addr), .wram_wdata(s_wram_wdata), .wram_we(s_wram_we),
    .wram_rdata(s_wram_rdata), .pat_addr(pat_addr), .pat_rom_addr(s_pat_rom_addr),
    .pat_rom_data(s_pat_rom_data), .pat_rdata(s_pat_rdata), .dbg_ctrl(s_dbg_ctrl),
    .dbg_en(s_dbg_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, {24'd0, dbg_ctrl}, {24'd0, m_ctrl});
    check(req, {31'd0, dbg_en}, {31'd0, m_en});
    check(req, {24'd0, s_dbg_ctrl}, {24'd0, m_ctrl});
    check(req, {31'd0, s_dbg_en}, {31'd0, m_en});
  endtask

  task automatic check_pat(input string req, input logic [12:0] a);
    pat_addr = a;
    #1;
    check(req, {19'd0, pat_rom_addr}, {19'd0, a});
    check(req, {24'd0, pat_rdata}, {24'd0, (m_en ? pat_f(a) : 8'h00)});
    check(req, {24'd0, s_pat_rdata}, {24'd0, (m_en ? pat_f(a) : 8'h00)});
  endtask

  task automatic do_reset(input logic [1:0] key);
    @(negedge clk);
    rst_n = 1'b0; cfg_key = key; cpu_wr = 1'b0; cpu_addr = 16'h0000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_ctrl = 8'h00; m_en = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    check("R8", {31'd0, wram_we}, {31'd0, (a[15:13] == 3'b011)});
    check("R8", {24'd0, wram_wdata}, {24'd0, d});
    check("R9", {31'd0, s_wram_we}, 32'd0);
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15]) begin
      m_ctrl = d;
      m_en = (cfg_key != 2'b00) && (d[1:0] == cfg_key);
    end
    #1;
    check_state(a[15] ? "R1/R2" : "R10");
  endtask

  task automatic cpu_read(input logic [15:0] a);
    logic [7:0] exp_big, exp_small;
    cpu_addr = a; cpu_wr = 1'b0; open_bus = 8'($urandom);
    #1;
    if (a[15]) begin
      exp_big = prg_f(a[14:0]);
      exp_small = prg_f({1'b0, a[13:0]});
      check("R6", {17'd0, prg_addr}, {17'd0, a[14:0]});
      check("R7", {18'd0, s_prg_addr}, {18'd0, a[13:0]});
    end else if (a[15:13] == 3'b011) begin
      exp_big = wram_f(a[12:0]);
      exp_small = open_bus;
      check("R8", {19'd0, wram_addr}, {19'd0, a[12:0]});
    end else begin
      exp_big = open_bus;
      exp_small = open_bus;
    end
    check("R6/R8", {24'd0, cpu_rdata}, {24'd0, exp_big});
    check("R7/R9", {24'd0, s_cpu_rdata}, {24'd0, exp_small});
    @(negedge clk);
    check_state("R10");
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_key = 2'b01; cpu_addr = '0; cpu_wdata = '0;
    cpu_wr = 1'b0; open_bus = 8'h55; pat_addr = '0;
    m_ctrl = '0; m_en = 1'b0;

    // R4: reset state, key 1
    do_reset(2'b01);
    check_state("R4");
    check_pat("R4", 13'h0000);
    check_pat("R5", 13'h1FFF);

    // R2, R5: key 1 enables on 0x01, 0x05, 0x09; 0x02 disables
    cpu_write(16'h8000, 8'h01);
    check_pat("R5", 13'h0000);
    cpu_write(16'hFFFF, 8'h02);
    check_pat("R5", 13'h1FFF);
    cpu_write(16'hC123, 8'h05);
    check_pat("R5", 13'h0ABC);
    cpu_write(16'h9000, 8'h09);
    // R10: writes below the program window do not touch the register
    cpu_write(16'h7FFF, 8'h02);
    cpu_write(16'h6000, 8'hAA);
    cpu_write(16'h1234, 8'h00);
    check_pat("R10", 13'h0010);

    // R6, R7: program mapping corners
    cpu_read(16'h8000);
    cpu_read(16'hC000);
    cpu_read(16'hFFFF);
    cpu_read(16'hBFFF);
    // R8, R9: work-RAM window and open bus
    cpu_read(16'h6000);
    cpu_read(16'h7FFF);
    cpu_read(16'h5FFF);

    // R2: key 2
    do_reset(2'b10);
    check_state("R4");
    cpu_write(16'h8000, 8'h01);
    check_pat("R2", 13'h0001);
    cpu_write(16'h8000, 8'h02);
    check_pat("R2", 13'h0002);

    // R3: key 0 never enables
    do_reset(2'b00);
    for (int v = 0; v < 4; v++) begin
      cpu_write(16'h8000 + 16'(v), 8'(v) | 8'hF0);
      check_pat("R3", 13'(v * 97));
    end

    // Random mix across all keys
    for (int k = 0; k < 4; k++) begin
      do_reset(2'(k));
      for (int i = 0; i < 300; i++) begin
        logic [15:0] a;
        a = 16'($urandom);
        if (($urandom % 3) == 0) a[15] = 1'b1;
        if (($urandom % 2) == 0) cpu_write(a, 8'($urandom));
        else cpu_read(a);
        check_pat("R5", 13'($urandom));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule